// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block derives the serial clock of an SPI master from a faster functional clock. Two dividers sit in series. A power-of-two prescaler, chosen by a 3-bit code, turns the functional clock into a stream of one-cycle ticks. A programmable divider then counts those ticks to form each serial clock period. The period is the prescale factor times the sum of an 8-bit divider value and two.

A transfer-active enable starts and stops the clock. While the enable is low, the output rests at the selected idle polarity, every counter is cleared, and the rate settings are captured. While the enable is high, the captured settings are frozen. Two single-cycle strobes mark the leading edge (idle level to active level) and the trailing edge (active level back to idle). A data shifter can use them directly.

Top module: `spi_sck_gen`

## Requirements
- R1: The prescale code `pre_code` = n selects a division factor F = 2^n, so code 0 divides by 1, code 3 by 8 and code 7 by 128.
- R2: While enabled, the serial clock period is F × (div_val + 2) functional clock cycles, for every divider value from 0 to 255.
- R3: When the edge before a cycle samples `enable` low, `sck` in that cycle equals the `cpol` sampled at that edge, both strobes are low, and the prescaler and phase counters are cleared.
- R4: After `enable` rises, the first leading edge is shown F × ceil(N/2) cycles after the first clock edge that samples `enable` high, where N = div_val + 2.
- R5: Each period holds the active level (opposite to `cpol`) for F × floor(N/2) cycles and the idle level for F × ceil(N/2) cycles.
- R6: `lead_stb` is high for exactly the one cycle in which `sck` first shows the active level. `trail_stb` is high for exactly the one cycle in which `sck` first shows the idle level again. The two strobes are never high together.
- R7: `pre_code`, `div_val` and `cpol` are captured only on edges that sample `enable` low. A change made while enabled has no effect on the running clock and applies from the next enable.
- R8: With prescale code 0 and divider value 6, the period is exactly 8 functional cycles, 4 active and 4 idle. With a 32 MHz functional clock this gives 4 MHz.
- R9: While `rst_n` is low, `sck`, `lead_stb` and `trail_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Transfer active; low holds the clock idle |
| pre_code | input | 3 | Prescale code n, factor 2^n |
| div_val | input | 8 | Divider value; period is F × (div_val + 2) |
| cpol | input | 1 | Idle level of the serial clock |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the idle-to-active edge |
| trail_stb | output | 1 | One-cycle strobe on the active-to-idle edge |

## Verification
The bench builds the block with its default widths: a 3-bit prescale code and an 8-bit divider. This makes the largest factor, 128, and the longest period, 257 ticks, reachable within the run. Each of the eight prescale codes is measured at divider values 0, 6 and 255, covering the shortest period, the example rate and the widest half-period count. Randomly drawn small codes and divider values, taken with both idle polarities, cover the odd-N split between the active and idle halves. Directed cases cover a settings change during a transfer and the return to idle.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;

  // Terminal count of the prescaler for code n: 2^n - 1, in a CNT_W-bit field.
  function automatic logic [6:0] pre_terminal(input logic [2:0] code);
    logic [6:0] t;
    t = '0;
    for (int i = 0; i < 7; i++) begin
      if (i < int'(code)) t[i] = 1'b1;
    end
    return t;
  endfunction

  // Ticks spent at the active level: floor((div + 2) / 2).
  function automatic logic [8:0] active_ticks(input logic [7:0] div);
    logic [8:0] n;
    n = {1'b0, div} + 9'd2;
    return n >> 1;
  endfunction

  // Ticks spent at the idle level: ceil((div + 2) / 2).
  function automatic logic [8:0] idle_ticks(input logic [7:0] div);
    logic [8:0] n;
    n = {1'b0, div} + 9'd3;
    return n >> 1;
  endfunction

endpackage

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold #(
  parameter int PRE_W = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] pre_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic             pol_in,
  output logic [PRE_W-1:0] pre_q,
  output logic [DIV_W-1:0] div_q,
  output logic             pol_q
);

  // Settings follow the inputs only while the clock is idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
      pol_q <= 1'b0;
    end else if (!enable) begin
      pre_q <= pre_in;
      div_q <= div_in;
      pol_q <= pol_in;
    end
  end

endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
  import sck_gen_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);

  localparam int CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term = pre_terminal(code);
  assign tick = enable && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enable || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sck_phase_gen.sv
module sck_phase_gen
  import sck_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_q,
  input  logic             pol_q,
  input  logic             pol_live,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             half_done
);

  localparam int PH_W = DIV_W + 1;

  logic            in_active_q;
  logic [PH_W-1:0] ph_cnt_q;
  logic [PH_W-1:0] half_len;

  assign half_len  = in_active_q ? active_ticks(div_q) : idle_ticks(div_q);
  assign half_done = tick && (ph_cnt_q == half_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_active_q <= 1'b0;
      ph_cnt_q    <= '0;
      sck         <= 1'b0;
      lead_stb    <= 1'b0;
      trail_stb   <= 1'b0;
    end else if (!enable) begin
      in_active_q <= 1'b0;
      ph_cnt_q    <= '0;
      sck         <= pol_live;
      lead_stb    <= 1'b0;
      trail_stb   <= 1'b0;
    end else begin
      lead_stb  <= half_done && !in_active_q;
      trail_stb <= half_done && in_active_q;
      if (half_done) begin
        in_active_q <= !in_active_q;
        ph_cnt_q    <= '0;
        sck         <= pol_q ^ !in_active_q;
      end else if (tick) begin
        ph_cnt_q <= ph_cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int PRE_W = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cpol,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb
);

  // Named internal events, visible to the bound checker.
  logic [PRE_W-1:0] cfg_pre;
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_pol;
  logic             pre_tick;
  logic             half_done;

  sck_cfg_hold #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .pre_in (pre_code),
    .div_in (div_val),
    .pol_in (cpol),
    .pre_q  (cfg_pre),
    .div_q  (cfg_div),
    .pol_q  (cfg_pol)
  );

  sck_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .code   (cfg_pre),
    .tick   (pre_tick)
  );

  sck_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (pre_tick),
    .div_q     (cfg_div),
    .pol_q     (cfg_pol),
    .pol_live  (cpol),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .half_done (half_done)
  );

endmodule

// File: rtl/sck_gen_chk.sv
module sck_gen_chk #(
  parameter int PRE_W = 3,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cpol,
  input logic             sck,
  input logic             lead_stb,
  input logic             trail_stb,
  input logic             half_done,
  input logic [PRE_W-1:0] cfg_pre,
  input logic [DIV_W-1:0] cfg_div
);

  // R3: an idle-sampling edge forces the idle level and quiet strobes.
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(enable)) |-> (sck == $past(cpol) && !lead_stb && !trail_stb));

  // R6: strobes never coincide.
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R6: a leading strobe lasts exactly one cycle.
  p_lead_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  // R6: every strobe coincides with a change of sck.
  p_strobe_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (lead_stb || trail_stb)) |-> (sck != $past(sck)));

  // R6: a toggle while running is always marked by a strobe.
  p_toggle_marked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable) && sck != $past(sck)) |-> (lead_stb || trail_stb));

  // R6: the finishing half-period produces a strobe on the next edge.
  p_half_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && half_done) |=> (lead_stb || trail_stb));

  // R7: captured settings do not move while running.
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(rst_n)) |-> ($stable(cfg_pre) && $stable(cfg_div)));

endmodule

bind spi_sck_gen sck_gen_chk #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cpol      (cpol),
  .sck       (sck),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb),
  .half_done (half_done),
  .cfg_pre   (cfg_pre),
  .cfg_div   (cfg_div)
);

// File: tb/tb_spi_sck_gen.sv
module tb_spi_sck_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] pre_code = '0;
  logic [7:0] div_val = '0;
  logic       cpol = 1'b0;
  logic       sck, lead_stb, trail_stb;

  int checks = 0;
  int failures = 0;
  longint cycles = 0;

  always #5 clk = ~clk;

  spi_sck_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pre_code(pre_code),
    .div_val(div_val), .cpol(cpol), .sck(sck), .lead_stb(lead_stb),
    .trail_stb(trail_stb)
  );

  // Bench model of the rate arithmetic.
  function automatic int factor_of(input int code);
    int f = 1;
    for (int i = 0; i < code; i++) f = f * 2;
    return f;
  endfunction
  function automatic int active_len(input int code, input int d);
    return factor_of(code) * ((d + 2) / 2);
  endfunction
  function automatic int idle_len(input int code, input int d);
    return factor_of(code) * ((d + 2) - (d + 2) / 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts posedges until the chosen strobe is seen at a negedge.
  task automatic wait_strobe(input bit want_lead, output int n);
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (want_lead ? lead_stb : trail_stb) break;
      if (n > 70000) break;
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  // Full measurement of one setting: first edge, active half, idle half.
  task automatic measure(input int code, input int d, input bit pol, input string tag);
    int n1, n2, n3;
    go_idle();
    pre_code = 3'(code);
    div_val  = 8'(d);
    cpol     = pol;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
    wait_strobe(1'b1, n1);
    check(n1 == idle_len(code, d), {tag, " R4 first lead"}, n1, idle_len(code, d));
    check(sck == !pol, {tag, " R6 active level at lead"}, int'(sck), int'(!pol));
    wait_strobe(1'b0, n2);
    check(n2 == active_len(code, d), {tag, " R5 active half"}, n2, active_len(code, d));
    check(sck == pol, {tag, " R6 idle level at trail"}, int'(sck), int'(pol));
    wait_strobe(1'b1, n3);
    check(n2 + n3 == factor_of(code) * (d + 2), {tag, " R1 R2 period"}, n2 + n3,
          factor_of(code) * (d + 2));
  endtask

  // Watchdog: a hang counts as a failure and still reports.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int seed_dummy;
    seed_dummy = $urandom(1234);
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset holds outputs low even with idle polarity high.
    check(sck == 1'b0 && !lead_stb && !trail_stb, "R9 reset state", int'(sck), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck == 1'b1, "R3 idle level after reset", int'(sck), 1);

    // R8: example rate.
    measure(0, 6, 1'b0, "R8 example");
    measure(0, 6, 1'b1, "R8 example pol1");

    // R1 R2: every code at divider 0, 6 and 255.
    for (int c = 0; c < 8; c++) begin
      measure(c, 0, 1'b0, "sweep d0");
      measure(c, 6, 1'b1, "sweep d6");
      measure(c, 255, 1'b0, "sweep d255");
    end

    // R5: random small settings, odd and even N, both polarities.
    for (int k = 0; k < 12; k++) begin
      measure(int'($urandom_range(4, 0)), int'($urandom_range(40, 0)),
              1'($urandom_range(1, 0)), "random R5");
    end

    // R7: change settings mid-transfer; running clock keeps old rate.
    go_idle();
    pre_code = 3'd1; div_val = 8'd2; cpol = 1'b0;
    @(negedge clk); @(negedge clk);
    enable = 1'b1;
    wait_strobe(1'b1, n);
    pre_code = 3'd0; div_val = 8'd0; cpol = 1'b1;
    wait_strobe(1'b0, n);
    check(n == 4, "R7 active half unchanged", n, 4);
    check(sck == 1'b0, "R7 polarity unchanged", int'(sck), 0);
    wait_strobe(1'b1, n);
    check(n == 4, "R7 idle half unchanged", n, 4);
    // Next enable uses the new settings (code 0, div 0, pol 1).
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sck == 1'b1 && !lead_stb && !trail_stb, "R3 drop to idle", int'(sck), 1);
    enable = 1'b1;
    wait_strobe(1'b1, n);
    check(n == 1, "R7 new settings at next enable", n, 1);
    check(sck == 1'b0, "R7 new polarity active level", int'(sck), 0);

    // R3: held idle for a while, no strobes and steady level.
    @(negedge clk);
    enable = 1'b0;
    cpol = 1'b0;
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (sck != 1'b0 || lead_stb || trail_stb) n++;
    end
    check(n == 0, "R3 idle quiet", n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule